// File: doc/BRIEF.md
# Dynamic Bus Sizing Write Sequencer

This block is the write side of a bus master that must store a 1, 2, 3 or 4 byte operand to a port whose width (8, 16 or 32 bits) is unknown when the transfer starts. A write is taken in on a valid/ready request. The sequencer then runs bus cycles. On every cycle it drives the current byte address, a size code that gives the bytes still to send, and a 32-bit data word. The word carries the pending bytes replicated across the lanes, so a port of any width finds its byte where it expects it.

The addressed port ends each bus cycle by returning a two-bit acknowledge code that also tells its width. From that code the sequencer works out how many bytes were taken. It then advances the address, drops the remaining count and starts the next cycle, most significant byte first, until the operand is gone. Misaligned start addresses are handled. While the acknowledge reads "none", the cycle is stretched one clock at a time with no limit. A one-cycle `done` pulse marks the end of a transfer.

Back-pressure rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high exactly when no bus transfer is in progress, including the cycle in which `done` pulses. While `req_ready` is low, the request inputs are ignored and the requester must hold its request.

Top module: `dbs_write_seq`

## Requirements
- R1: After reset, `bus_cyc` and `done` are low and `req_ready` is high.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are high. `bus_cyc` is high from the next cycle until the final acknowledge. While `bus_cyc` is high, `req_ready` is low and request inputs have no effect.
- R3: `bus_siz` gives the bytes still to be sent: 01 = one, 10 = two, 11 = three, 00 = four. The first cycle carries the requested count, coded the same way on `req_bytes`.
- R4: `bus_ack` codes are 10 = 8-bit port, 01 = 16-bit port, 00 = 32-bit port, 11 = no acknowledge. With 11, the cycle continues and address, size and data stay unchanged for any number of clocks.
- R5: On an acknowledge, the port accepts the following. An 8-bit port takes one byte. A 16-bit port takes bytes up to the end of the current halfword. A 32-bit port takes bytes up to the end of the current word. Neither may take more than remain. The address then advances, and the remaining count drops, by that number.
- R6: With offset o = `bus_addr[1:0]` and pending bytes b0 (next to send), b1, b2, b3, where bytes past the remaining count are zero, the data lanes are filled as follows. D31-D24 = b0. D23-D16 = b0 if o is odd, else b1. D15-D8 = b2, b1, b0, b0 for o = 0, 1, 2, 3. D7-D0 = b3, b2, b1, b0 for o = 0, 1, 2, 3.
- R7: The operand is the low n bytes of `req_data`. It is sent most significant byte first.
- R8: `done` is high for exactly one cycle, the cycle after the final acknowledge, and `bus_cyc` is low in that cycle.
- R9: `bus_ack` has no effect while `bus_cyc` is low.
- R10: A long write takes 4 cycles to an 8-bit port. It takes 2 cycles to a 16-bit port when aligned, and 3 when it starts at an odd address. It takes 1 cycle to a 32-bit port when aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer free to take a request |
| req_addr | input | ADDR_W | Byte address of the operand's most significant byte |
| req_data | input | 32 | Operand, right-aligned |
| req_bytes | input | 2 | Operand length, size-code coding |
| bus_cyc | output | 1 | Bus write cycle in progress |
| bus_addr | output | ADDR_W | Byte address of the current cycle |
| bus_siz | output | 2 | Bytes remaining, size-code coding |
| bus_wdata | output | 32 | Replicated write data |
| bus_ack | input | 2 | Acknowledge and port width code |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Directed long writes to each port width, aligned and misaligned, separate the three acceptance rules. They also expose a wrong cycle count. Short and three-byte operands at every offset exercise the zero fill and the lane choice per offset, which a single aligned case cannot distinguish. Random mixes of length, offset, width and wait states, with requests held high while the sequencer is busy, are compared each clock against a byte-queue model. These runs show that stretched cycles hold their outputs and that busy-time requests are ignored.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int DATA_W = BYTE_W * LANES;
  localparam int CNT_W  = 3;

  typedef enum logic [1:0] {
    ACK_W32  = 2'b00,
    ACK_W16  = 2'b01,
    ACK_W8   = 2'b10,
    ACK_WAIT = 2'b11
  } ack_code_e;
endpackage

// File: rtl/dbs_step_calc.sv
module dbs_step_calc
  import dbs_pkg::*;
(
  input  logic [1:0]       ack,
  input  logic [1:0]       off,
  input  logic [CNT_W-1:0] remain,
  output logic             accepted,
  output logic [CNT_W-1:0] take
);
  logic [CNT_W-1:0] cap;

  always_comb begin
    unique case (ack_code_e'(ack))
      ACK_W8:  cap = CNT_W'(1);
      ACK_W16: cap = CNT_W'(2) - CNT_W'(off[0]);
      ACK_W32: cap = CNT_W'(LANES) - CNT_W'(off);
      default: cap = '0;
    endcase
    accepted = (ack_code_e'(ack) != ACK_WAIT);
    take     = (remain < cap) ? remain : cap;
  end
endmodule

// File: rtl/dbs_lane_mux.sv
module dbs_lane_mux
  import dbs_pkg::*;
(
  input  logic [1:0]        off,
  input  logic [DATA_W-1:0] pend,
  output logic [DATA_W-1:0] wdata
);
  for (genvar p = 0; p < LANES; p++) begin : g_lane
    logic [1:0] idx;
    always_comb begin
      if (p == 0)
        idx = 2'd0;
      else if (p == 1)
        idx = off[0] ? 2'd0 : 2'd1;
      else if (2'(p) >= off)
        idx = 2'(p) - off;
      else
        idx = 2'd0;
    end
    assign wdata[DATA_W-1-BYTE_W*p -: BYTE_W] = pend[DATA_W-1-BYTE_W*idx -: BYTE_W];
  end
endmodule

// File: rtl/dbs_write_seq.sv
module dbs_write_seq
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [1:0]        req_bytes,
  output logic              bus_cyc,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_siz,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [1:0]        bus_ack,
  output logic              done
);
  localparam int SH_W = $clog2(DATA_W) + 1;

  logic              busy_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] pend_q;

  logic              acc;
  logic [CNT_W-1:0]  take;
  logic [CNT_W-1:0]  load_cnt;
  logic [SH_W-1:0]   load_sh, step_sh;

  dbs_step_calc u_step (
    .ack      (bus_ack),
    .off      (addr_q[1:0]),
    .remain   (cnt_q),
    .accepted (acc),
    .take     (take)
  );

  dbs_lane_mux u_lanes (
    .off   (addr_q[1:0]),
    .pend  (pend_q),
    .wdata (bus_wdata)
  );

  assign load_cnt = (req_bytes == 2'b00) ? CNT_W'(LANES) : CNT_W'(req_bytes);
  assign load_sh  = SH_W'((CNT_W'(LANES) - load_cnt) * BYTE_W);
  assign step_sh  = SH_W'(take * BYTE_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
      pend_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_valid) begin
          busy_q <= 1'b1;
          addr_q <= req_addr;
          cnt_q  <= load_cnt;
          pend_q <= req_data << load_sh;
        end
      end else if (acc) begin
        addr_q <= addr_q + ADDR_W'(take);
        cnt_q  <= cnt_q - take;
        pend_q <= pend_q << step_sh;
        if (take == cnt_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign req_ready = !busy_q;
  assign bus_cyc   = busy_q;
  assign bus_addr  = addr_q;
  assign bus_siz   = cnt_q[1:0];
  assign done      = done_q;
endmodule

// File: rtl/dbs_write_seq_chk.sv
module dbs_write_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_bytes,
  input logic              bus_cyc,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_siz,
  input logic [31:0]       bus_wdata,
  input logic [1:0]        bus_ack,
  input logic              done
);
  // R2
  busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> !req_ready);

  // R3
  start_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (bus_cyc && bus_siz == $past(req_bytes) && bus_addr == $past(req_addr)));

  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_ack == 2'b11) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_siz) && $stable(bus_wdata)));

  // R5
  byte_port_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_ack == 2'b10 && bus_siz != 2'b01) |=>
      (bus_cyc && bus_addr == $past(bus_addr) + ADDR_W'(1) && bus_siz == $past(bus_siz) - 2'd1));

  // R6
  odd_lane_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_addr[0]) |-> (bus_wdata[23:16] == bus_wdata[31:24]));

  // R8
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_cyc && $past(bus_cyc) && $past(bus_ack) != 2'b11));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  idle_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cyc && !req_valid) |=> !bus_cyc);
endmodule

bind dbs_write_seq dbs_write_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_bytes (req_bytes),
  .bus_cyc   (bus_cyc),
  .bus_addr  (bus_addr),
  .bus_siz   (bus_siz),
  .bus_wdata (bus_wdata),
  .bus_ack   (bus_ack),
  .done      (done)
);

// File: tb/dbs_write_seq_bench.sv
module dbs_write_seq_bench;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_data = '0;
  logic [1:0]    req_bytes = 2'b00;
  logic          bus_cyc;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_siz;
  logic [31:0]   bus_wdata;
  logic [1:0]    bus_ack = 2'b11;
  logic          done;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  bit            m_busy = 0;
  bit            m_done = 0;
  logic [AW-1:0] m_addr = '0;
  logic [7:0]    m_q[$];

  always #5 clk = ~clk;

  dbs_write_seq #(.ADDR_W(AW)) u_dbs_write_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_bytes(req_bytes),
    .bus_cyc(bus_cyc), .bus_addr(bus_addr), .bus_siz(bus_siz),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] qb(input int i);
    return (i < m_q.size()) ? m_q[i] : 8'h00;
  endfunction

  function automatic logic [31:0] exp_lanes(input logic [1:0] o);
    logic [31:0] w;
    w[31:24] = qb(0);
    w[23:16] = o[0] ? qb(0) : qb(1);
    w[15:8]  = (o <= 2) ? qb(2 - int'(o)) : qb(0);
    w[7:0]   = qb(3 - int'(o));
    return w;
  endfunction

  function automatic int port_take(input logic [1:0] ack, input logic [1:0] o, input int rem);
    int cap;
    case (ack)
      2'b10:   cap = 1;
      2'b01:   cap = 2 - int'(o[0]);
      2'b00:   cap = 4 - int'(o);
      default: cap = 0;
    endcase
    return (rem < cap) ? rem : cap;
  endfunction

  // one clock: compare outputs with the model, drive inputs, advance the model
  task automatic step(input bit v, input logic [31:0] a, input logic [31:0] d,
                      input logic [1:0] nb, input logic [1:0] ack);
    @(negedge clk);
    chk(bus_cyc == m_busy, "R2 bus_cyc", 64'(bus_cyc), 64'(m_busy));
    chk(req_ready == !m_busy, "R2 req_ready", 64'(req_ready), 64'(!m_busy));
    chk(done == m_done, "R8 done", 64'(done), 64'(m_done));
    if (m_busy) begin
      chk(bus_addr == m_addr, "R5 bus_addr", 64'(bus_addr), 64'(m_addr));
      chk(bus_siz == 2'(m_q.size()), "R3 bus_siz", 64'(bus_siz), 64'(m_q.size() % 4));
      chk(bus_wdata == exp_lanes(m_addr[1:0]), "R6 bus_wdata", 64'(bus_wdata), 64'(exp_lanes(m_addr[1:0])));
    end
    req_valid = v; req_addr = a; req_data = d; req_bytes = nb; bus_ack = ack;
    m_done = 0;
    if (!m_busy) begin
      if (v) begin
        int n = (nb == 2'b00) ? 4 : int'(nb);
        m_q.delete();
        for (int i = n - 1; i >= 0; i--) m_q.push_back(d[8*i +: 8]);
        m_addr = a;
        m_busy = 1;
      end
    end else if (ack != 2'b11) begin
      int k = port_take(ack, m_addr[1:0], m_q.size());
      for (int i = 0; i < k; i++) void'(m_q.pop_front());
      m_addr = m_addr + AW'(k);
      if (m_q.size() == 0) begin
        m_busy = 0;
        m_done = 1;
      end
    end
  endtask

  // runs one write, returns the number of acknowledged bus cycles
  task automatic transfer(input logic [31:0] a, input logic [31:0] d, input logic [1:0] nb,
                          input logic [1:0] ack, input int waits, output int ncyc);
    ncyc = 0;
    step(1, a, d, nb, 2'b11);
    while (m_busy) begin
      for (int w = 0; w < waits; w++) step(1, ~a, ~d, nb + 2'd1, 2'b11);
      step(1, ~a, ~d, nb + 2'd1, ack);
      ncyc++;
    end
    step(0, '0, '0, 2'b00, 2'b11);
  endtask

  initial begin
    int nc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(bus_cyc == 1'b0, "R1 bus_cyc", 64'(bus_cyc), 0);
    chk(done == 1'b0, "R1 done", 64'(done), 0);
    chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 1);

    // R9 acknowledge while idle
    step(0, '0, '0, 2'b00, 2'b10);
    step(0, '0, '0, 2'b00, 2'b00);
    step(0, '0, '0, 2'b00, 2'b11);
    chk(bus_cyc == 1'b0, "R9 idle ack", 64'(bus_cyc), 0);

    // R10 cycle counts for long writes
    transfer(32'h2010_7420, 32'h02A1_0512, 2'b00, 2'b10, 0, nc);
    chk(nc == 4, "R10 long 8-bit", 64'(nc), 4);
    transfer(32'h4000_2050, 32'h1122_3344, 2'b00, 2'b01, 0, nc);
    chk(nc == 2, "R10 long 16-bit aligned", 64'(nc), 2);
    transfer(32'h4000_2051, 32'h5566_7788, 2'b00, 2'b01, 1, nc);
    chk(nc == 3, "R10 long 16-bit odd", 64'(nc), 3);
    transfer(32'h0000_0100, 32'hCAFE_F00D, 2'b00, 2'b00, 2, nc);
    chk(nc == 1, "R10 long 32-bit aligned", 64'(nc), 1);

    // R7 three-byte operand, most significant first
    step(1, 32'h0000_0013, 32'hFFAB_CDEF, 2'b11, 2'b11);
    step(0, '0, '0, 2'b00, 2'b11);
    chk(bus_wdata[31:24] == 8'hAB, "R7 first byte", 64'(bus_wdata[31:24]), 64'hAB);
    // R4 wait holds address
    chk(bus_addr == 32'h13, "R4 held addr", 64'(bus_addr), 64'h13);
    step(0, '0, '0, 2'b00, 2'b10);
    step(0, '0, '0, 2'b00, 2'b10);
    step(0, '0, '0, 2'b00, 2'b11);
    chk(bus_wdata[31:24] == 8'hEF, "R7 last byte", 64'(bus_wdata[31:24]), 64'hEF);
    step(0, '0, '0, 2'b00, 2'b10);
    step(0, '0, '0, 2'b00, 2'b11);

    // R5 R6 every offset, length and width
    for (int o = 0; o < 4; o++)
      for (int n = 0; n < 4; n++)
        for (int w = 0; w < 3; w++)
          transfer(32'h8000_0000 + 32'(o), 32'h9A8B_7C6D ^ 32'(o * 37 + n), 2'(n), 2'(w), 0, nc);

    // random mix with wait states
    for (int t = 0; t < 60; t++)
      transfer($urandom, $urandom, 2'($urandom), 2'($urandom % 3), int'($urandom % 4), nc);

    step(0, '0, '0, 2'b00, 2'b11);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule